// File: doc/BRIEF.md
# Mailbox and IRQ Interrupt Aggregator

This block gathers two kinds of interrupt source into one host-facing interrupt request. The first kind is a bank of mailbox registers. A write from the local bus master to a mailbox stores the data and raises a sticky flag that stays set until software clears it. The second kind is a set of level-sensitive IRQ inputs. These are synchronised into the clock domain and shown live, with no latching.

The block has one status word and one enable word. The status word holds the sticky mailbox flags next to the live IRQ levels. The enable word masks each of those bits one by one. When any status bit is set and its enable bit is also set, the block raises a registered level output. On each rising edge of that condition it also pulses a one-cycle message request. The host side chooses which of the two it uses.

The register bus is a simple single-cycle port. A write is taken on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `mbx_irq_agg`

## Requirements
- R1: After reset all mailbox contents, mailbox flags and enable bits are zero, and `irq_level` and `msg_req` are low.
- R2: Mailbox n sits at byte address 0x800 + 4·n for n = 0..7. It is a 32-bit read/write register whose stored value reads back unchanged.
- R3: A write to mailbox n sets status bit 16+n on the write edge. No status flag becomes 1 without a write to its mailbox.
- R4: A write to the status word (address 0x040) clears every flag in bits 23:16 where the written bit is 1, and leaves flags unchanged where the written bit is 0. Written bits 15:0 and 31:24 have no effect.
- R5: Status bit i (bits 15:0) shows `irq_in[i]` through a two-stage synchroniser. A change on the input is seen on the second rising edge after it is applied, and not before.
- R6: The enable word at address 0x050 stores written bits 23:0 and reads them back. Bit 16+n enables mailbox flag n and bit i enables IRQ input i. Bits 31:24 of both the status and enable words read zero.
- R7: `irq_level` goes high one clock after any status bit and its enable bit are both 1. It goes low one clock after no such pair remains.
- R8: `msg_req` is high for exactly one cycle, in the same cycle that `irq_level` rises. It stays low while `irq_level` stays high or low.
- R9: Addresses other than the status word, the enable word and the eight word-aligned mailboxes read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 16 | Level-sensitive local interrupt inputs |
| irq_level | output | 1 | Registered host interrupt level |
| msg_req | output | 1 | One-cycle message interrupt request |

## Verification
Each result has its own due time, and the bench samples it there.
- Register contents, flag sets and flag clears can be read on the falling edge right after the write edge, because read data is combinational.
- An IRQ input change reaches the status word after two rising edges. The bench reads once after one edge, expecting no change, and again after two edges, expecting the new value.
- `irq_level` and `msg_req` rise one edge after the status change that enables them. The bench checks them low at the first falling edge, high at the next one, and then checks that `msg_req` has dropped one cycle later.

All sampling happens on falling edges, so no result depends on the order of processes at the active edge.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int REG_W         = 32;
  localparam int MBX_FIELD_LSB = 16;
  localparam int STAT_OFF      = 'h040;
  localparam int ENA_OFF       = 'h050;
  localparam int MBX_OFF       = 'h800;

  // Assemble a register word from the mailbox field and the IRQ field.
  function automatic logic [REG_W-1:0] place_fields(input logic [7:0] mbx_f,
                                                     input logic [15:0] irq_f);
    return {8'h00, mbx_f, irq_f};
  endfunction

  // Sticky flag next state: a set has priority over a clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Edge detector used for the request pulse.
  function automatic logic rising(input logic now, input logic prev);
    return now & ~prev;
  endfunction
endpackage

// File: rtl/mbx_irq_sync.sv
module mbx_irq_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_irq_pkg::*;
#(
  parameter int NUM_MBX = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MBX-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_MBX-1:0] clr_mask,
  output logic [DATA_W-1:0] slot_data [NUM_MBX],
  output logic [NUM_MBX-1:0] flags
);
  for (genvar n = 0; n < NUM_MBX; n++) begin : g_slot
    logic [DATA_W-1:0] data_q;
    logic              flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        flag_q <= 1'b0;
      end else begin
        if (wr_sel[n]) data_q <= wr_data;
        flag_q <= flag_next(flag_q, wr_sel[n], clr_mask[n]);
      end
    end

    assign slot_data[n] = data_q;
    assign flags[n]     = flag_q;
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen
  import mbx_irq_pkg::*;
#(
  parameter int SRC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [SRC_W-1:0] ena,
  output logic             hit_any,
  output logic             level,
  output logic             pulse
);
  logic level_q;
  logic pulse_q;

  assign hit_any = |(src & ena);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      level_q <= hit_any;
      pulse_q <= rising(hit_any, level_q);
    end
  end

  assign level = level_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/mbx_irq_agg.sv
module mbx_irq_agg
  import mbx_irq_pkg::*;
#(
  parameter int NUM_MBX = 8,
  parameter int NUM_IRQ = 16,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic              irq_level,
  output logic              msg_req
);
  localparam int IDX_W = (NUM_MBX > 1) ? $clog2(NUM_MBX) : 1;
  localparam int SRC_W = NUM_MBX + NUM_IRQ;
  localparam logic [ADDR_W-1:0] STAT_A    = ADDR_W'(STAT_OFF);
  localparam logic [ADDR_W-1:0] ENA_A     = ADDR_W'(ENA_OFF);
  localparam logic [ADDR_W-1:0] MBX_BASE_A = ADDR_W'(MBX_OFF);
  localparam logic [ADDR_W-1:0] MBX_END_A  = ADDR_W'(MBX_OFF + 4 * NUM_MBX);

  // Address decode
  logic             sel_stat;
  logic             sel_ena;
  logic             sel_mbx;
  logic [IDX_W-1:0] mbx_idx;

  assign sel_stat = (bus_addr == STAT_A);
  assign sel_ena  = (bus_addr == ENA_A);
  assign sel_mbx  = (bus_addr >= MBX_BASE_A) && (bus_addr < MBX_END_A) &&
                    (bus_addr[1:0] == 2'b00);
  assign mbx_idx  = IDX_W'((bus_addr - MBX_BASE_A) >> 2);

  // Write events brought out for the checker
  logic [NUM_MBX-1:0] mbx_wr;
  logic [NUM_MBX-1:0] w1c_mask;

  always_comb begin
    for (int n = 0; n < NUM_MBX; n++) begin
      mbx_wr[n] = bus_we && sel_mbx && (mbx_idx == IDX_W'(n));
    end
    w1c_mask = (bus_we && sel_stat) ? bus_wdata[MBX_FIELD_LSB +: NUM_MBX] : '0;
  end

  // Mailboxes and sticky flags
  logic [REG_W-1:0]   mbx_data [NUM_MBX];
  logic [NUM_MBX-1:0] flags;

  mbx_bank #(.NUM_MBX(NUM_MBX), .DATA_W(REG_W)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel   (mbx_wr),
    .wr_data  (bus_wdata),
    .clr_mask (w1c_mask),
    .slot_data(mbx_data),
    .flags    (flags)
  );

  // Live IRQ levels after synchronisation
  logic [NUM_IRQ-1:0] irq_sync;

  mbx_irq_sync #(.WIDTH(NUM_IRQ)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(irq_in),
    .sync_out(irq_sync)
  );

  // Enable register
  logic [NUM_MBX-1:0] en_mbx_q;
  logic [NUM_IRQ-1:0] en_irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mbx_q <= '0;
      en_irq_q <= '0;
    end else if (bus_we && sel_ena) begin
      en_mbx_q <= bus_wdata[MBX_FIELD_LSB +: NUM_MBX];
      en_irq_q <= bus_wdata[NUM_IRQ-1:0];
    end
  end

  // Interrupt generation
  logic hit_any;

  mbx_irq_gen #(.SRC_W(SRC_W)) gen_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    ({flags, irq_sync}),
    .ena    ({en_mbx_q, en_irq_q}),
    .hit_any(hit_any),
    .level  (irq_level),
    .pulse  (msg_req)
  );

  // Read mux
  logic [REG_W-1:0] stat_word;
  logic [REG_W-1:0] ena_word;

  assign stat_word = place_fields(8'(flags), 16'(irq_sync));
  assign ena_word  = place_fields(8'(en_mbx_q), 16'(en_irq_q));

  always_comb begin
    bus_rdata = '0;
    if (sel_stat)      bus_rdata = stat_word;
    else if (sel_ena)  bus_rdata = ena_word;
    else if (sel_mbx)  bus_rdata = mbx_data[mbx_idx];
  end
endmodule

// File: rtl/mbx_irq_agg_chk.sv
module mbx_irq_agg_chk #(
  parameter int NUM_MBX = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_MBX-1:0] mbx_set,
  input logic [NUM_MBX-1:0] mbx_clr,
  input logic [NUM_MBX-1:0] mbx_flags,
  input logic               hit_any,
  input logic               irq_level,
  input logic               msg_req
);
  // R3: a mailbox write leaves its flag set
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|mbx_set) |=> ((mbx_flags & $past(mbx_set)) == $past(mbx_set)));

  // R3: a flag never becomes 1 without a mailbox write
  assert_no_spurious_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mbx_flags & ~$past(mbx_flags) & ~$past(mbx_set)) == '0));

  // R4: a clear with no set in the same cycle drops the flag
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mbx_clr & ~mbx_set)) |=> ((mbx_flags & $past(mbx_clr & ~mbx_set)) == '0));

  // R7: with no enabled source the level falls on the next edge
  assert_idle_drops_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |=> !irq_level);

  // R8: the request is a single cycle
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |=> !msg_req);

  // R8: the request only appears together with the level
  assert_pulse_with_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> irq_level);

  // R8: every rise of the level carries a request
  assert_rise_gives_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_level) |-> msg_req);
endmodule

bind mbx_irq_agg mbx_irq_agg_chk #(.NUM_MBX(NUM_MBX)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mbx_set  (mbx_wr),
  .mbx_clr  (w1c_mask),
  .mbx_flags(flags),
  .hit_any  (hit_any),
  .irq_level(irq_level),
  .msg_req  (msg_req)
);

// File: tb/mbx_irq_agg_tb_top.sv
`timescale 1ns/1ps
module mbx_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_in = '0;
  logic        irq_level;
  logic        msg_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mbx_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_level(irq_level), .msg_req(msg_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mbx_pattern(input int n);
    return 32'hC3A5_0000 ^ (32'h0101_0101 * (n + 1)) ^ (32'h1 << (3 * n));
  endfunction

  initial begin
    logic [31:0] v;
    logic [7:0]  exp_flags;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1: reset state
    check("R1 level", {31'b0, irq_level}, 32'h0);
    check("R1 msg", {31'b0, msg_req}, 32'h0);
    rd(12'h040, v); check("R1 status", v, 32'h0);
    rd(12'h050, v); check("R1 enable", v, 32'h0);
    for (int n = 0; n < 8; n++) begin
      rd(12'h800 + 12'(4 * n), v); check("R1 mailbox", v, 32'h0);
    end

    // R2/R3: write every mailbox, read back, watch flags accumulate
    exp_flags = '0;
    for (int n = 0; n < 8; n++) begin
      wr(12'h800 + 12'(4 * n), mbx_pattern(n));
      exp_flags[n] = 1'b1;
      rd(12'h040, v); check("R3 flag set", v, {8'h00, exp_flags, 16'h0000});
      check("R7 no enable no level", {31'b0, irq_level}, 32'h0);
    end
    for (int n = 0; n < 8; n++) begin
      rd(12'h800 + 12'(4 * n), v); check("R2 readback", v, mbx_pattern(n));
    end

    // R4: zero and non-flag bits leave flags alone
    wr(12'h040, 32'h0000_0000);
    rd(12'h040, v); check("R4 zero write", v, 32'h00FF_0000);
    wr(12'h040, 32'hFF00_FFFF);
    rd(12'h040, v); check("R4 other bits", v, 32'h00FF_0000);
    for (int n = 0; n < 8; n++) begin
      wr(12'h040, 32'h1 << (16 + n));
      exp_flags[n] = 1'b0;
      rd(12'h040, v); check("R4 clear one", v, {8'h00, exp_flags, 16'h0000});
    end
    rd(12'h808, v); check("R4 data kept", v, mbx_pattern(2));

    // R6: enable register and reserved bits
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, v); check("R6 enable all", v, 32'h00FF_FFFF);
    wr(12'h050, 32'h005A_C3E1);
    rd(12'h050, v); check("R6 enable pattern", v, 32'h005A_C3E1);
    wr(12'h050, 32'h0000_0000);
    rd(12'h050, v); check("R6 enable clear", v, 32'h0);

    // R5: each IRQ input, two-edge latency
    for (int i = 0; i < 16; i++) begin
      irq_in = 16'h1 << i;
      step();
      rd(12'h040, v); check("R5 not yet", v, 32'h0);
      step();
      rd(12'h040, v); check("R5 visible", v, 32'h1 << i);
      irq_in = '0;
      step(); step();
      rd(12'h040, v); check("R5 released", v, 32'h0);
    end

    // R7/R8: mailbox source
    wr(12'h050, 32'h1 << 19);
    wr(12'h80C, 32'h1234_5678);
    check("R7 level lag", {31'b0, irq_level}, 32'h0);
    step();
    check("R7 level up", {31'b0, irq_level}, 32'h1);
    check("R8 pulse", {31'b0, msg_req}, 32'h1);
    step();
    check("R8 pulse ends", {31'b0, msg_req}, 32'h0);
    wr(12'h814, 32'h0000_0001);
    step();
    check("R7 level held", {31'b0, irq_level}, 32'h1);
    check("R8 no second pulse", {31'b0, msg_req}, 32'h0);
    wr(12'h040, 32'h1 << 19);
    check("R7 level still up", {31'b0, irq_level}, 32'h1);
    step();
    check("R7 level down", {31'b0, irq_level}, 32'h0);
    check("R8 no pulse on fall", {31'b0, msg_req}, 32'h0);
    wr(12'h040, 32'h1 << 21);

    // R7/R8: IRQ source, plus a disabled one
    wr(12'h050, 32'h1 << 7);
    irq_in = 16'h0004;
    repeat (4) step();
    check("R7 disabled irq", {31'b0, irq_level}, 32'h0);
    irq_in = 16'h0084;
    step(); step();
    check("R7 irq lag", {31'b0, irq_level}, 32'h0);
    step();
    check("R7 irq level", {31'b0, irq_level}, 32'h1);
    check("R8 irq pulse", {31'b0, msg_req}, 32'h1);
    step();
    check("R8 irq pulse ends", {31'b0, msg_req}, 32'h0);
    irq_in = '0;
    repeat (3) step();
    check("R7 irq release", {31'b0, irq_level}, 32'h0);

    // R9: unmapped addresses
    rd(12'h060, v); check("R9 read hole", v, 32'h0);
    rd(12'h820, v); check("R9 past mailboxes", v, 32'h0);
    rd(12'h802, v); check("R9 misaligned", v, 32'h0);
    wr(12'h060, 32'hFFFF_FFFF);
    wr(12'h822, 32'hFFFF_FFFF);
    rd(12'h040, v); check("R9 status untouched", v, 32'h0);
    rd(12'h050, v); check("R9 enable untouched", v, 32'h0000_0080);
    rd(12'h800, v); check("R9 mailbox untouched", v, mbx_pattern(0));

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule